// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control words reached over a plain single-cycle bus: a byte address, write data, a write strobe, a read strobe, and read data that comes back one clock later. It decodes a 4 KiB window. The lower 2 KiB holds general storage of 512 words. Higher in the window there is one write-only command word, and it asks the rest of the chip for a system reset or a shutdown.

After reset, four words in the storage region hold fixed identification patterns. When three of them are read, bits 29:28 are forced high in the returned value, and the stored copy is left as it was. Any access that misses the storage region raises a one-cycle error pulse, and a read of that kind returns zero. The one exception is a valid command write.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, storage word 0x40 (byte 0x100) holds 0x05F20121, word 0x41 (byte 0x104) holds 0x00000002, word 0x42 (byte 0x108) holds 0x05F30121, and word 0x43 (byte 0x10C) holds 0x05F40121. Every other word holds zero. All three outputs are low.
- R2: A write to a byte offset below 0x800 stores the data in word offset/4. A read of that word one cycle or more later returns the data on `rd_data` in the cycle after the read strobe.
- R3: A read at byte 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000, and the stored word itself is not modified. For example, after writing zero to 0x100, a read there returns 0x30000000.
- R4: A read at byte 0x104 returns exactly the stored word, with no bits forced.
- R5: A write of 1 or 2 to byte 0xF00 drives `sys_reset_req` high for one cycle, in the cycle after the write. No error pulse is raised.
- R6: A write of 3 to byte 0xF00 drives `sys_shutdown_req` high for one cycle, in the cycle after the write. No error pulse is raised.
- R7: A write to byte 0xF00 of any other value raises neither request and no error.
- R8: A write at byte 0x800 or above, other than to 0xF00, changes no stored word and pulses `access_err` in the cycle after the write. The command word is never stored.
- R9: A read at byte 0x800 or above returns zero and pulses `access_err` in the cycle after the read strobe.
- R10: Address bits 1:0 are ignored. Every access acts on the aligned 32-bit word.
- R11: When a read and a write to the same word occur in the same cycle, the read returns the value held before the write, and the write takes effect.
- R12: Each request pulse and each error pulse lasts exactly one cycle when the strobes are idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| sys_reset_req | output | 1 | One-cycle reset request |
| sys_shutdown_req | output | 1 | One-cycle shutdown request |
| access_err | output | 1 | One-cycle out-of-range access flag |

## Verification
A read and a write can land in the same cycle, and the address can match both of them. The bench drives both strobes together on one storage word. It expects the returned data to be the old content and a later read to show the new content. The same collision is also provoked at the command word: a command write combined with a read must still raise its request, while the read half is judged as an out-of-range read that returns zero and raises the error flag.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int STORE_WORDS = 512;
    localparam int WIDX_W      = ADDR_W - 2;
    localparam int SIDX_W      = $clog2(STORE_WORDS);
    localparam logic [WIDX_W-1:0] CMD_WIDX = WIDX_W'(12'hF00 >> 2);
    localparam logic [DATA_W-1:0] ID_FORCE = 32'h3000_0000;

    typedef struct packed {
        logic              in_store;
        logic              is_cmd;
        logic [SIDX_W-1:0] sidx;
    } dec_t;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_SHUTDOWN = 2'd2
    } cmd_e;

    function automatic logic [DATA_W-1:0] word_reset_value(input int unsigned idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] read_force(input logic [SIDX_W-1:0] idx);
        if (idx == SIDX_W'(9'h40) || idx == SIDX_W'(9'h42) || idx == SIDX_W'(9'h43))
            return ID_FORCE;
        return '0;
    endfunction

    function automatic cmd_e decode_cmd(input logic [DATA_W-1:0] v);
        if (v == 32'd1 || v == 32'd2) return CMD_RESET;
        if (v == 32'd3)               return CMD_SHUTDOWN;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [WIDX_W-1:0] widx;
    logic              unused_lsb;

    assign widx       = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        dec.in_store = (widx < WIDX_W'(STORE_WORDS));
        dec.is_cmd   = (widx == CMD_WIDX);
        dec.sidx     = widx[SIDX_W-1:0];
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int NWORDS = STORE_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem[i] <= word_reset_value(i);
            end
        end else if (wr && dec.in_store) begin
            mem[dec.sidx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= dec.in_store ? (mem[dec.sidx] | read_force(dec.sidx)) : '0;
        end
    end
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              reset_req,
    output logic              shutdown_req
);
    cmd_e cmd;

    always_comb begin
        cmd = CMD_NONE;
        if (wr && dec.is_cmd) cmd = decode_cmd(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_req    <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            reset_req    <= (cmd == CMD_RESET);
            shutdown_req <= (cmd == CMD_SHUTDOWN);
        end
    end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              sys_reset_req,
    output logic              sys_shutdown_req,
    output logic              access_err
);
    dec_t dec;
    logic err_now;

    sysctl_addr_dec u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    sysctl_store #(.NWORDS(STORE_WORDS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .rdata (rd_data)
    );

    sysctl_cmd u_cmd (
        .clk          (clk),
        .rst          (rst),
        .dec          (dec),
        .wr           (bus_wr),
        .wdata        (bus_wdata),
        .reset_req    (sys_reset_req),
        .shutdown_req (sys_shutdown_req)
    );

    assign err_now = (bus_wr && !dec.in_store && !dec.is_cmd) ||
                     (bus_rd && !dec.in_store);

    always_ff @(posedge clk) begin
        if (rst) access_err <= 1'b0;
        else     access_err <= err_now;
    end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic              sys_reset_req,
    input logic              sys_shutdown_req,
    input logic              access_err
);
    logic cmd_hit;
    logic high_hit;
    assign cmd_hit  = (bus_addr[11:2] == 10'h3C0);
    assign high_hit = bus_addr[11];

    assert_reset_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && cmd_hit && (bus_wdata == 32'd1 || bus_wdata == 32'd2))
        |=> (sys_reset_req && !sys_shutdown_req));

    assert_shutdown_cmd_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && cmd_hit && bus_wdata == 32'd3) |=> (sys_shutdown_req && !sys_reset_req));

    assert_other_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && cmd_hit && !(bus_wdata inside {32'd1, 32'd2, 32'd3}))
        |=> (!sys_reset_req && !sys_shutdown_req && !access_err));

    assert_bad_write_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && high_hit && !cmd_hit) |=> access_err);

    assert_bad_read_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && high_hit) |=> (access_err && rd_data == '0));

    assert_req_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(sys_reset_req && sys_shutdown_req));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (.*);

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] rd_data;
    logic        sys_reset_req, sys_shutdown_req, access_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_regfile dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_data(rd_data),
        .sys_reset_req(sys_reset_req), .sys_shutdown_req(sys_shutdown_req),
        .access_err(access_err)
    );

    // vector: {is_read, addr[11:0], wdata[31:0], exp_rdata[31:0], exp_err, req[7:0]}
    localparam int NV = 20;
    localparam logic [85:0] VEC [NV] = '{
        {1'b1, 12'h100, 32'h0, 32'h35F2_0121, 1'b0, 8'd3},
        {1'b1, 12'h104, 32'h0, 32'h0000_0002, 1'b0, 8'd4},
        {1'b1, 12'h108, 32'h0, 32'h35F3_0121, 1'b0, 8'd3},
        {1'b1, 12'h10C, 32'h0, 32'h35F4_0121, 1'b0, 8'd3},
        {1'b1, 12'h000, 32'h0, 32'h0000_0000, 1'b0, 8'd1},
        {1'b0, 12'h010, 32'hA5A5_0001, 32'h0, 1'b0, 8'd2},
        {1'b1, 12'h010, 32'h0, 32'hA5A5_0001, 1'b0, 8'd2},
        {1'b0, 12'h7FC, 32'hDEAD_BEEF, 32'h0, 1'b0, 8'd2},
        {1'b1, 12'h7FC, 32'h0, 32'hDEAD_BEEF, 1'b0, 8'd2},
        {1'b1, 12'h7FF, 32'h0, 32'hDEAD_BEEF, 1'b0, 8'd10},
        {1'b0, 12'h023, 32'h1234_5678, 32'h0, 1'b0, 8'd10},
        {1'b1, 12'h020, 32'h0, 32'h1234_5678, 1'b0, 8'd10},
        {1'b0, 12'h104, 32'h0, 32'h0, 1'b0, 8'd4},
        {1'b1, 12'h104, 32'h0, 32'h0000_0000, 1'b0, 8'd4},
        {1'b0, 12'h100, 32'h0, 32'h0, 1'b0, 8'd3},
        {1'b1, 12'h100, 32'h0, 32'h3000_0000, 1'b0, 8'd3},
        {1'b0, 12'h800, 32'h1111_1111, 32'h0, 1'b1, 8'd8},
        {1'b1, 12'h000, 32'h0, 32'h0000_0000, 1'b0, 8'd8},
        {1'b1, 12'h800, 32'h0, 32'h0000_0000, 1'b1, 8'd9},
        {1'b1, 12'hFFC, 32'h0, 32'h0000_0000, 1'b1, 8'd9}
    };

    function automatic string rq(input int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge; outputs of that access are sampled one cycle later
    task automatic access(input logic w, input logic r, input logic [11:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic outs(input string req, input logic rr, input logic sr, input logic er);
        check(req, "reset_req", {31'b0, sys_reset_req}, {31'b0, rr});
        check(req, "shutdown_req", {31'b0, sys_shutdown_req}, {31'b0, sr});
        check(req, "access_err", {31'b0, access_err}, {31'b0, er});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state of outputs
        outs("R1", 1'b0, 1'b0, 1'b0);
        check("R1", "rd_data", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [85:0] v;
            v = VEC[i];
            access(!v[85], v[85], v[84:73], v[72:41]);
            if (v[85]) check(rq(int'(v[7:0])), "rd_data", rd_data, v[40:9]);
            check(rq(int'(v[7:0])), "access_err", {31'b0, access_err}, {31'b0, v[8]});
        end

        // R5 command values 1 and 2
        access(1'b1, 1'b0, 12'hF00, 32'd1);
        outs("R5", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        outs("R12", 1'b0, 1'b0, 1'b0);
        access(1'b1, 1'b0, 12'hF00, 32'd2);
        outs("R5", 1'b1, 1'b0, 1'b0);
        // R6 shutdown
        access(1'b1, 1'b0, 12'hF00, 32'd3);
        outs("R6", 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        outs("R12", 1'b0, 1'b0, 1'b0);
        // R7 other values
        access(1'b1, 1'b0, 12'hF00, 32'd4);
        outs("R7", 1'b0, 1'b0, 1'b0);
        access(1'b1, 1'b0, 12'hF00, 32'd0);
        outs("R7", 1'b0, 1'b0, 1'b0);
        access(1'b1, 1'b0, 12'hF03, 32'h0000_0103);
        outs("R7", 1'b0, 1'b0, 1'b0);
        // R8 command never stored: no alias in storage, reading it is out of range
        access(1'b0, 1'b1, 12'h700, 32'd0);
        check("R8", "alias word rd_data", rd_data, 32'h0);
        access(1'b0, 1'b1, 12'hF00, 32'd0);
        check("R8", "command word rd_data", rd_data, 32'h0);
        outs("R9", 1'b0, 1'b0, 1'b1);

        // R11 collision on one storage word
        access(1'b1, 1'b0, 12'h040, 32'hCAFE_0000);
        access(1'b1, 1'b1, 12'h040, 32'h0BAD_0000);
        check("R11", "old value on collision", rd_data, 32'hCAFE_0000);
        access(1'b0, 1'b1, 12'h040, 32'd0);
        check("R11", "new value after collision", rd_data, 32'h0BAD_0000);
        // R11 collision on the command word
        access(1'b1, 1'b1, 12'hF00, 32'd3);
        outs("R11", 1'b0, 1'b1, 1'b1);
        check("R11", "rd_data on command collision", rd_data, 32'h0);

        // R1 reset restores the identification words
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        access(1'b0, 1'b1, 12'h10C, 32'd0);
        check("R1", "word 0x43 after reset", rd_data, 32'h35F4_0121);
        access(1'b0, 1'b1, 12'h010, 32'd0);
        check("R1", "word 0x04 after reset", rd_data, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule